// File: doc/BRIEF.md
# PCM Sample Packing Word FIFO

This block sits at the end of an audio decimation path. It takes 16-bit PCM samples, each tagged with a channel number, and packs them two to a 32-bit word. Completed words go into a small first-in first-out store that a host drains one word at a time. A mode input selects how the two halves of each word are filled. In mono mode, two consecutive channel-0 samples form a word. In stereo mode, one channel-0 sample and one channel-1 sample form a word.

The host sets a fill threshold. A data-available flag tells it when enough words are waiting. Words that arrive when there is no room are dropped. A drop also sets a sticky overflow flag, which stays set until the host clears it. The read port is show-ahead: the oldest stored word is always present on the read data output, and a read strobe removes it.

Top module: `pcm_pack_fifo`

## Requirements
- R1: After reset, the fill level is 0, the overflow flag is 0 and the read data is 0.
- R2: In mono mode, each word holds two channel-0 samples. The earlier sample is in bits [31:16] and the later sample is in bits [15:0].
- R3: In stereo mode, each word holds the channel-1 sample in bits [31:16] and the channel-0 sample in bits [15:0], whichever of the two arrives first. The word is stored on the clock edge that takes in its second half.
- R4: In mono mode, a sample tagged channel 1 is ignored and does not occupy a half of any word.
- R5: Words leave in the order they were stored. The fill level rises by one per stored word and falls by one per read strobe taken while the store is not empty.
- R6: The data-available flag is 1 exactly when the fill level is greater than or equal to the 4-bit threshold. A threshold of 0 keeps the flag at 1.
- R7: The store holds at most 16 words. A word completed while the store is full, with no read strobe in the same cycle, is dropped and the stored words are unchanged. The drop sets the overflow flag. The flag holds until an overflow-clear strobe arrives in a cycle with no new drop.
- R8: While the store is empty, the read data is 0, and a read strobe leaves the fill level and the read position unchanged.
- R9: While the enable input is 0, incoming samples are ignored and any half-packed word is discarded. After re-enabling, packing starts from an empty word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Accept samples when 1 |
| stereo | input | 1 | 0: mono packing, 1: stereo packing |
| smp_data | input | 16 | PCM sample |
| smp_chan | input | 1 | Channel tag of the sample |
| smp_valid | input | 1 | Sample present this cycle |
| avail_thresh | input | 4 | Fill threshold for the available flag |
| rd_strobe | input | 1 | Remove the oldest word |
| ovf_clr | input | 1 | Clear the overflow flag |
| rd_data | output | 32 | Oldest stored word, 0 when empty |
| data_avail | output | 1 | Fill level is at or above the threshold |
| ovf_flag | output | 1 | Sticky overflow indication |
| fill_level | output | 5 | Number of stored words |

## Verification
The bench builds the block with its default parameters: 16-bit samples and a 16-word store. With these values the store can be filled to its true limit within a few hundred cycles, so the full boundary and the dropped seventeenth word are both reached. Threshold values of 0, 1 and 4 are used, covering the always-on setting and the edge where the flag rises. Both stereo arrival orders are driven, and so is a disable in the middle of a half-packed mono word.

// File: rtl/pcm_pack_pkg.sv
package pcm_pack_pkg;

    localparam int SMP_W      = 16;
    localparam int FIFO_DEPTH = 16;

    // One half of a word under assembly
    typedef struct packed {
        logic             full;
        logic [SMP_W-1:0] data;
    } half_t;

    typedef enum logic {
        MODE_MONO   = 1'b0,
        MODE_STEREO = 1'b1
    } pack_mode_e;

    // Choose the half a new sample belongs in
    function automatic logic pick_slot(input pack_mode_e mode,
                                       input logic chan,
                                       input logic hi_full);
        if (mode == MODE_STEREO) return chan;
        return hi_full ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/pcm_packer.sv
module pcm_packer
    import pcm_pack_pkg::*;
#(
    parameter int SW = SMP_W,
    localparam int WW = 2 * SW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  pack_mode_e    mode,
    input  logic          in_valid,
    input  logic          in_chan,
    input  logic [SW-1:0] in_data,
    output logic          push,
    output logic [WW-1:0] word
);

    half_t slot_q [2];
    logic  take;
    logic  tgt;

    assign take = en && in_valid && !(mode == MODE_MONO && in_chan);
    assign tgt  = pick_slot(mode, in_chan, slot_q[1].full);
    assign push = take && slot_q[!tgt].full;
    assign word = {tgt ? in_data : slot_q[1].data,
                   tgt ? slot_q[0].data : in_data};

    for (genvar i = 0; i < 2; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || !en) begin
                slot_q[i] <= '0;
            end else if (push) begin
                slot_q[i] <= '0;
            end else if (take && tgt == i[0]) begin
                slot_q[i] <= '{full: 1'b1, data: in_data};
            end
        end
    end

endmodule

// File: rtl/pcm_word_fifo.sv
module pcm_word_fifo
    import pcm_pack_pkg::*;
#(
    parameter int W     = 2 * SMP_W,
    parameter int DEPTH = FIFO_DEPTH,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_req,
    input  logic          ovf_clr,
    output logic [W-1:0]  rd_data,
    output logic [LW-1:0] level,
    output logic          ovf
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [LW-1:0] cnt_q;
    logic          do_rd, do_wr, drop;

    assign do_rd = rd_req && (cnt_q != '0);
    assign do_wr = wr_req && ((cnt_q != LW'(DEPTH)) || do_rd);
    assign drop  = wr_req && !do_wr;

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp_q] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_wr) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (do_rd) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            cnt_q <= cnt_q + LW'(do_wr) - LW'(do_rd);
            if (drop)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end

    assign rd_data = (cnt_q != '0) ? mem[rp_q] : '0;
    assign level   = cnt_q;

endmodule

// File: rtl/pcm_pack_fifo.sv
module pcm_pack_fifo
    import pcm_pack_pkg::*;
#(
    parameter int SW    = SMP_W,
    parameter int DEPTH = FIFO_DEPTH,
    localparam int WW = 2 * SW,
    localparam int TW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en,
    input  logic          stereo,
    input  logic [SW-1:0] smp_data,
    input  logic          smp_chan,
    input  logic          smp_valid,
    input  logic [TW-1:0] avail_thresh,
    input  logic          rd_strobe,
    input  logic          ovf_clr,
    output logic [WW-1:0] rd_data,
    output logic          data_avail,
    output logic          ovf_flag,
    output logic [LW-1:0] fill_level
);

    logic          push;
    logic [WW-1:0] word;
    pack_mode_e    mode;

    assign mode = stereo ? MODE_STEREO : MODE_MONO;

    pcm_packer #(.SW(SW)) u_pack (
        .clk      (clk),
        .rst      (rst),
        .en       (fifo_en),
        .mode     (mode),
        .in_valid (smp_valid),
        .in_chan  (smp_chan),
        .in_data  (smp_data),
        .push     (push),
        .word     (word)
    );

    pcm_word_fifo #(.W(WW), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (push),
        .wr_data (word),
        .rd_req  (rd_strobe),
        .ovf_clr (ovf_clr),
        .rd_data (rd_data),
        .level   (fill_level),
        .ovf     (ovf_flag)
    );

    assign data_avail = fill_level >= LW'(avail_thresh);

endmodule

// File: rtl/pcm_pack_chk.sv
module pcm_pack_chk
    import pcm_pack_pkg::*;
#(
    localparam int LW = $clog2(FIFO_DEPTH + 1),
    localparam int WW = 2 * SMP_W
) (
    input logic          clk,
    input logic          rst,
    input logic          fifo_en,
    input logic          smp_valid,
    input logic          rd_strobe,
    input logic          ovf_clr,
    input logic [WW-1:0] rd_data,
    input logic          ovf_flag,
    input logic [LW-1:0] fill_level
);

    // R7
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill_level <= LW'(FIFO_DEPTH));

    // R8
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_level == '0) |-> (rd_data == '0));

    // R7
    ovf_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> ($past(fill_level) == LW'(FIFO_DEPTH)));

    // R7
    ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && !rd_strobe) |=> $stable(fill_level));

    // R5
    pop_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && fill_level != '0 && !smp_valid) |=>
            (fill_level == $past(fill_level) - 1'b1));

endmodule

bind pcm_pack_fifo pcm_pack_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .fifo_en    (fifo_en),
    .smp_valid  (smp_valid),
    .rd_strobe  (rd_strobe),
    .ovf_clr    (ovf_clr),
    .rd_data    (rd_data),
    .ovf_flag   (ovf_flag),
    .fill_level (fill_level)
);

// File: tb/sim_pcm_pack_fifo.sv
module sim_pcm_pack_fifo;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fifo_en = 1'b0;
    logic        stereo = 1'b0;
    logic [15:0] smp_data = '0;
    logic        smp_chan = 1'b0;
    logic        smp_valid = 1'b0;
    logic [3:0]  avail_thresh = 4'd1;
    logic        rd_strobe = 1'b0;
    logic        ovf_clr = 1'b0;
    logic [31:0] rd_data;
    logic        data_avail;
    logic        ovf_flag;
    logic [4:0]  fill_level;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [31:0] exp_q [$];

    always #4 clk = ~clk;

    pcm_pack_fifo u0 (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .stereo(stereo),
        .smp_data(smp_data), .smp_chan(smp_chan), .smp_valid(smp_valid),
        .avail_thresh(avail_thresh), .rd_strobe(rd_strobe), .ovf_clr(ovf_clr),
        .rd_data(rd_data), .data_avail(data_avail), .ovf_flag(ovf_flag),
        .fill_level(fill_level)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic smp(input logic ch, input logic [15:0] d);
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = ch; smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic pop_chk(input string req);
        logic [31:0] e;
        @(negedge clk);
        e = exp_q.pop_front();
        chk(req, rd_data, e);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 fill", 32'(fill_level), 0);
        chk("R1 ovf", 32'(ovf_flag), 0);
        chk("R1 data", rd_data, 0);
        chk("R6 thr1 empty", 32'(data_avail), 0);
        avail_thresh = 4'd0;
        @(negedge clk);
        chk("R6 thr0", 32'(data_avail), 1);
        avail_thresh = 4'd1;
    endtask

    task automatic t_mono;
        stereo = 1'b0;
        smp(0, 16'h1111); smp(1, 16'hDEAD); smp(0, 16'h2222);
        smp(0, 16'h3333); smp(1, 16'hBEEF); smp(0, 16'h4444);
        exp_q.push_back(32'h1111_2222);
        exp_q.push_back(32'h3333_4444);
        chk("R5 fill mono", 32'(fill_level), 2);
        pop_chk("R2 R4 word0");
        pop_chk("R2 R4 word1");
        chk("R5 drained", 32'(fill_level), 0);
    endtask

    task automatic t_stereo;
        stereo = 1'b1;
        smp(0, 16'hA000); smp(1, 16'hB001);
        chk("R3 fill after pair", 32'(fill_level), 1);
        smp(1, 16'hC002); smp(0, 16'hD003);
        exp_q.push_back(32'hB001_A000);
        exp_q.push_back(32'hC002_D003);
        pop_chk("R3 ch0 first");
        pop_chk("R3 ch1 first");
        stereo = 1'b0;
    endtask

    task automatic t_thresh;
        avail_thresh = 4'd4;
        for (int i = 0; i < 3; i++) begin
            smp(0, 16'(i)); smp(0, 16'(i + 100));
            exp_q.push_back({16'(i), 16'(i + 100)});
        end
        chk("R6 below", 32'(data_avail), 0);
        smp(0, 16'h0055); smp(0, 16'h0066);
        exp_q.push_back(32'h0055_0066);
        chk("R6 at thr", 32'(data_avail), 1);
        for (int i = 0; i < 4; i++) pop_chk("R5 thresh drain");
        avail_thresh = 4'd1;
    endtask

    task automatic t_overflow;
        for (int i = 0; i < 16; i++) begin
            smp(0, 16'(16'h200 + i)); smp(0, 16'(16'h300 + i));
            exp_q.push_back({16'(16'h200 + i), 16'(16'h300 + i)});
        end
        chk("R7 full", 32'(fill_level), 16);
        chk("R7 no ovf yet", 32'(ovf_flag), 0);
        smp(0, 16'hFFFF); smp(0, 16'hEEEE);
        chk("R7 ovf set", 32'(ovf_flag), 1);
        chk("R7 fill held", 32'(fill_level), 16);
        for (int i = 0; i < 16; i++) pop_chk("R7 contents");
        chk("R7 sticky", 32'(ovf_flag), 1);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        chk("R7 cleared", 32'(ovf_flag), 0);
    endtask

    task automatic t_empty;
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
        chk("R8 data", rd_data, 0);
        chk("R8 fill", 32'(fill_level), 0);
        smp(0, 16'h7A7A); smp(0, 16'h5B5B);
        exp_q.push_back(32'h7A7A_5B5B);
        pop_chk("R8 pointer kept");
    endtask

    task automatic t_disable;
        smp(0, 16'h0BAD);
        @(negedge clk); fifo_en = 1'b0;
        smp(0, 16'h0C0C); smp(0, 16'h0D0D);
        chk("R9 ignored", 32'(fill_level), 0);
        @(negedge clk); fifo_en = 1'b1;
        smp(0, 16'h1234); smp(0, 16'h5678);
        exp_q.push_back(32'h1234_5678);
        chk("R9 fill", 32'(fill_level), 1);
        pop_chk("R9 fresh word");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        fifo_en = 1'b1;
        t_mono();
        t_stereo();
        t_thresh();
        t_overflow();
        t_empty();
        t_disable();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule